// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Peripheral Function Multiplexing

This block is the register file and pin steering logic for one sixteen-pin general-purpose I/O port. Each pin has an output latch, a direction bit, an input-enable bit, a function-enable bit and a two-bit function selector. When a pin's function-enable bit is clear, the port drives the pad from its own latch and direction bits. When the bit is set, one of four peripheral functions drives the pad's output value and output enable. The selector for that pin picks which function.

Software reaches the port through a simple single-cycle register bus. A write is taken on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The output latch and the direction register each have write-one-to-set and write-one-to-clear aliases, so a driver can change one pin without a read-modify-write sequence. The pad input passes through a two-stage synchroniser before it can be read. The block has no state machine. Every register updates directly from the bus decode on each clock edge.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted and after it is released, every register is zero. Every pin is then a GPIO input with input disabled, `pad_oe` and `pad_out` are 0, and every read returns 0.
- R2: The register map places the output latch at address 0, and a write there replaces the latch. Address 1 is the set alias: each 1 in `bus_wdata[15:0]` sets that latch bit. Address 2 is the clear alias: each 1 clears that latch bit. Bits written as 0 through either alias keep their value.
- R3: Direction is at address 3, and a write there replaces it. Address 4 is the direction set alias: each 1 makes that pin an output. Address 5 is the direction clear alias: each 1 makes that pin an input. Bits written as 0 through either alias keep their value.
- R4: A write that makes a pin an output clears that pin's input-enable bit (address 6) on the same edge. Such a write is a 1 written to address 3 or to address 4. Input-enable bits of the other pins are unchanged.
- R5: For a pin whose function-enable bit (address 7) is 0 and whose direction bit is 1, bit n of a read at address 0 returns the pin's output latch.
- R6: For any other pin, bit n of a read at address 0 returns the pad value if input enable is 1, and 0 if it is 0. The pad value is taken through two clock stages, so a pad change is visible after the second rising edge that follows it.
- R7: For a pin whose function-enable bit is 0, `pad_oe[n]` equals the direction bit and `pad_out[n]` equals the output latch bit.
- R8: For a pin whose function-enable bit is 1, the output value and output enable come from function f. Here f is the selector in bits 2n+1..2n of the 32-bit selector register at address 8. Pin n of function f is `fn_dout[16*f+n]` and `fn_den[16*f+n]`.
- R9: Reads at addresses 3, 6, 7 and 8 return the written register contents. Reads at the alias addresses 1, 2, 4 and 5, and at addresses 9 to 15, return 0.
- R10: Writes to addresses 9 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 16 | Pad input values, asynchronous |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| fn_dout | input | 64 | Peripheral output values, function f pin n at bit 16f+n |
| fn_den | input | 64 | Peripheral output enables, same packing |

## Verification
Two things can land on the same clock edge. The first is a direction write that turns a pin into an output. That write also clears the pin's input enable on the same edge, and this changes what the data read returns on that edge. The bench provokes it by enabling inputs on pins and then setting their direction. It then reads back both the input-enable register and the data register. The second collision is a pad transition that is still inside the synchroniser when a pin's direction or function enable flips. The bench judges both collisions, and a long pseudo-random mix of writes and pad changes, against a behavioural model that it compares on every clock.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    localparam int unsigned GPM_PINS        = 16;
    localparam int unsigned GPM_FUNCS       = 4;
    localparam int unsigned GPM_SYNC_STAGES = 2;
    localparam int unsigned GPM_ADDR_W      = 4;

    typedef enum logic [GPM_ADDR_W-1:0] {
        REG_LATCH     = 4'd0,
        REG_LATCH_SET = 4'd1,
        REG_LATCH_CLR = 4'd2,
        REG_DIR       = 4'd3,
        REG_DIR_SET   = 4'd4,
        REG_DIR_CLR   = 4'd5,
        REG_INEN      = 4'd6,
        REG_FNEN      = 4'd7,
        REG_FSEL      = 4'd8
    } gpm_reg_e;

endpackage

// File: rtl/gpm_regfile.sv
module gpm_regfile
    import gpm_pkg::*;
#(
    parameter int unsigned PINS  = GPM_PINS,
    parameter int unsigned SEL_W = 2,
    localparam int unsigned FW   = SEL_W * PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GPM_ADDR_W-1:0] wr_addr,
    input  logic [FW-1:0]         wr_data,
    output logic [PINS-1:0]       data_q,
    output logic [PINS-1:0]       dir_q,
    output logic [PINS-1:0]       inen_q,
    output logic [PINS-1:0]       fnen_q,
    output logic [FW-1:0]         fsel_q
);

    logic [PINS-1:0] wd;
    logic [PINS-1:0] latch_set, latch_clr, dir_set, dir_clr, made_out;
    logic [PINS-1:0] data_n, dir_n, inen_n, fnen_n;
    logic [FW-1:0]   fsel_n;

    assign wd = wr_data[PINS-1:0];

    always_comb begin
        latch_set = '0;
        latch_clr = '0;
        dir_set   = '0;
        dir_clr   = '0;
        data_n    = data_q;
        dir_n     = dir_q;
        inen_n    = inen_q;
        fnen_n    = fnen_q;
        fsel_n    = fsel_q;
        if (wr_en) begin
            unique case (wr_addr)
                REG_LATCH:     data_n    = wd;
                REG_LATCH_SET: latch_set = wd;
                REG_LATCH_CLR: latch_clr = wd;
                REG_DIR:       dir_n     = wd;
                REG_DIR_SET:   dir_set   = wd;
                REG_DIR_CLR:   dir_clr   = wd;
                REG_INEN:      inen_n    = wd;
                REG_FNEN:      fnen_n    = wd;
                REG_FSEL:      fsel_n    = wr_data;
                default:       ;
            endcase
        end
        // set and clear never share a cycle on one bus; clear wins regardless
        data_n   = (data_n | latch_set) & ~latch_clr;
        dir_n    = (dir_n | dir_set) & ~dir_clr;
        made_out = dir_set | ((wr_en && wr_addr == REG_DIR) ? wd : '0);
        inen_n   = inen_n & ~made_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            inen_q <= '0;
            fnen_q <= '0;
            fsel_q <= '0;
        end else begin
            data_q <= data_n;
            dir_q  <= dir_n;
            inen_q <= inen_n;
            fnen_q <= fnen_n;
            fsel_q <= fsel_n;
        end
    end

endmodule

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);

    logic [PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpm_pinmux.sv
module gpm_pinmux #(
    parameter int unsigned PINS  = 16,
    parameter int unsigned FUNCS = 4,
    localparam int unsigned SEL_W = $clog2(FUNCS),
    localparam int unsigned FW    = SEL_W * PINS
) (
    input  logic [PINS-1:0]       data_q,
    input  logic [PINS-1:0]       dir_q,
    input  logic [PINS-1:0]       fnen_q,
    input  logic [FW-1:0]         fsel_q,
    input  logic [FUNCS*PINS-1:0] fn_dout,
    input  logic [FUNCS*PINS-1:0] fn_den,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [SEL_W-1:0] sel;
        logic [FUNCS-1:0] cand_o, cand_e;

        assign sel = fsel_q[SEL_W*p +: SEL_W];

        for (genvar f = 0; f < FUNCS; f++) begin : g_fn
            assign cand_o[f] = fn_dout[f*PINS + p];
            assign cand_e[f] = fn_den[f*PINS + p];
        end

        assign pad_out[p] = fnen_q[p] ? cand_o[sel] : data_q[p];
        assign pad_oe[p]  = fnen_q[p] ? cand_e[sel] : dir_q[p];
    end

endmodule

// File: rtl/gpm_readback.sv
module gpm_readback
    import gpm_pkg::*;
#(
    parameter int unsigned PINS = GPM_PINS,
    parameter int unsigned FW   = 2 * GPM_PINS
) (
    input  logic [GPM_ADDR_W-1:0] rd_addr,
    input  logic [PINS-1:0]       data_q,
    input  logic [PINS-1:0]       dir_q,
    input  logic [PINS-1:0]       inen_q,
    input  logic [PINS-1:0]       fnen_q,
    input  logic [FW-1:0]         fsel_q,
    input  logic [PINS-1:0]       pad_sync,
    output logic [FW-1:0]         rd_data
);

    logic [PINS-1:0] pin_state;

    always_comb begin
        for (int n = 0; n < PINS; n++) begin
            if (!fnen_q[n] && dir_q[n]) pin_state[n] = data_q[n];
            else                        pin_state[n] = inen_q[n] & pad_sync[n];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_LATCH: rd_data[PINS-1:0] = pin_state;
            REG_DIR:   rd_data[PINS-1:0] = dir_q;
            REG_INEN:  rd_data[PINS-1:0] = inen_q;
            REG_FNEN:  rd_data[PINS-1:0] = fnen_q;
            REG_FSEL:  rd_data           = fsel_q;
            default:   rd_data           = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpm_pkg::*;
#(
    parameter int unsigned PINS        = GPM_PINS,
    parameter int unsigned FUNCS       = GPM_FUNCS,
    parameter int unsigned SYNC_STAGES = GPM_SYNC_STAGES,
    localparam int unsigned SEL_W      = $clog2(FUNCS),
    localparam int unsigned FW         = SEL_W * PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [GPM_ADDR_W-1:0] bus_addr,
    input  logic [FW-1:0]         bus_wdata,
    output logic [FW-1:0]         bus_rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    input  logic [FUNCS*PINS-1:0] fn_dout,
    input  logic [FUNCS*PINS-1:0] fn_den
);

    logic [PINS-1:0] data_q, dir_q, inen_q, fnen_q, pad_sync;
    logic [FW-1:0]   fsel_q;

    gpm_regfile #(.PINS(PINS), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .inen_q  (inen_q),
        .fnen_q  (fnen_q),
        .fsel_q  (fsel_q)
    );

    gpm_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpm_pinmux #(.PINS(PINS), .FUNCS(FUNCS)) u_mux (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .fnen_q  (fnen_q),
        .fsel_q  (fsel_q),
        .fn_dout (fn_dout),
        .fn_den  (fn_den),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpm_readback #(.PINS(PINS), .FW(FW)) u_rd (
        .rd_addr  (bus_addr),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .inen_q   (inen_q),
        .fnen_q   (fnen_q),
        .fsel_q   (fsel_q),
        .pad_sync (pad_sync),
        .rd_data  (bus_rdata)
    );

endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
    import gpm_pkg::*;
#(
    parameter int unsigned PINS = GPM_PINS,
    parameter int unsigned FW   = 2 * GPM_PINS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [GPM_ADDR_W-1:0] bus_addr,
    input logic [FW-1:0]         bus_wdata,
    input logic [PINS-1:0]       pad_oe,
    input logic [PINS-1:0]       data_q,
    input logic [PINS-1:0]       dir_q,
    input logic [PINS-1:0]       inen_q,
    input logic [PINS-1:0]       fnen_q,
    input logic [FW-1:0]         fsel_q
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && dir_q == '0 && inen_q == '0 && fnen_q == '0));

    assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_LATCH_SET) |=>
        ((data_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    assert_latch_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_LATCH_CLR) |=>
        ((data_q & $past(bus_wdata[PINS-1:0])) == '0));

    assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR_CLR) |=>
        ((dir_q & $past(bus_wdata[PINS-1:0])) == '0));

    assert_out_drops_inen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR_SET) |=>
        ((inen_q & $past(bus_wdata[PINS-1:0])) == '0));

    assert_gpio_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ dir_q) & ~fnen_q) == '0);

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > REG_FSEL) |=>
        ($stable(data_q) && $stable(dir_q) && $stable(inen_q) &&
         $stable(fnen_q) && $stable(fsel_q)));

endmodule

bind gpio_mux_port gpm_checker #(.PINS(PINS), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .inen_q    (inen_q),
    .fnen_q    (fnen_q),
    .fsel_q    (fsel_q)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic [63:0] fn_dout = '0;
    logic [63:0] fn_den = '0;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [15:0] m_data, m_dir, m_inen, m_fnen, m_s1, m_s2;
    logic [31:0] m_fsel;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fn_dout(fn_dout), .fn_den(fn_den)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [3:0] a);
        logic [15:0] v;
        for (int n = 0; n < 16; n++)
            v[n] = (!m_fnen[n] && m_dir[n]) ? m_data[n] : (m_inen[n] & m_s2[n]);
        case (a)
            4'd0:    return {16'h0, v};
            4'd3:    return {16'h0, m_dir};
            4'd6:    return {16'h0, m_inen};
            4'd7:    return {16'h0, m_fnen};
            4'd8:    return m_fsel;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_edge();
        logic [15:0] w;
        w = bus_wdata[15:0];
        if (!rst_n) begin
            m_data = '0; m_dir = '0; m_inen = '0; m_fnen = '0;
            m_fsel = '0; m_s1 = '0; m_s2 = '0;
            return;
        end
        m_s2 = m_s1;
        m_s1 = pad_in;
        if (bus_wr) begin
            case (bus_addr)
                4'd0: m_data = w;
                4'd1: m_data = m_data | w;
                4'd2: m_data = m_data & ~w;
                4'd3: begin m_dir = w; m_inen = m_inen & ~w; end
                4'd4: begin m_dir = m_dir | w; m_inen = m_inen & ~w; end
                4'd5: m_dir = m_dir & ~w;
                4'd6: m_inen = w;
                4'd7: m_fnen = w;
                4'd8: m_fsel = bus_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        logic [15:0] eo, ee;
        for (int n = 0; n < 16; n++) begin
            if (m_fnen[n]) begin
                int f;
                f = int'(m_fsel[2*n +: 2]);
                eo[n] = fn_dout[16*f + n];
                ee[n] = fn_den[16*f + n];
            end else begin
                eo[n] = m_data[n];
                ee[n] = m_dir[n];
            end
        end
        check(m_fnen != 0 ? "R8" : "R7", "pad_out", {16'h0, pad_out}, {16'h0, eo});
        check(m_fnen != 0 ? "R8" : "R7", "pad_oe",  {16'h0, pad_oe},  {16'h0, ee});
        check(cur_req, "bus_rdata", bus_rdata, model_read(bus_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [3:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, "read", bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick();
        check("R1", "pad_oe in reset", {16'h0, pad_oe}, 32'h0);
        rst_n = 1'b1;
        tick();
        rd_expect("R1", 4'd0, 32'h0);
        rd_expect("R1", 4'd8, 32'h0);
        check("R1", "pad_out after reset", {16'h0, pad_out}, 32'h0);

        // R2: latch writes and aliases
        cur_req = "R2";
        wr(4'd0, 32'h0000_00F0);
        wr(4'd1, 32'h0000_0F01);
        wr(4'd2, 32'h0000_0030);
        wr(4'd3, 32'h0000_FFFF);
        bus_addr = 4'd0; tick();
        // R5: outputs read back the latch
        rd_expect("R5", 4'd0, 32'h0000_0FC1);
        check("R7", "pad_out gpio", {16'h0, pad_out}, 32'h0000_0FC1);
        check("R7", "pad_oe gpio", {16'h0, pad_oe}, 32'h0000_FFFF);

        // R3: direction aliases
        cur_req = "R3";
        wr(4'd5, 32'h0000_FF00);
        wr(4'd4, 32'h0000_0100);
        rd_expect("R3", 4'd3, 32'h0000_01FF);

        // R4: making outputs drops input enable
        cur_req = "R4";
        wr(4'd6, 32'h0000_FFFF);
        wr(4'd4, 32'h0000_000F);
        rd_expect("R4", 4'd6, 32'h0000_FFF0);
        rd_expect("R4", 4'd3, 32'h0000_01FF);

        // R6: synchronised pad input
        cur_req = "R6";
        pad_in = 16'hA5A5;
        wr(4'd5, 32'h0000_FFFF);
        wr(4'd6, 32'h0000_00FF);
        bus_addr = 4'd0; tick();
        rd_expect("R6", 4'd0, 32'h0000_00A5);
        pad_in = 16'h5A5A;
        tick();
        rd_expect("R6", 4'd0, 32'h0000_00A5);
        tick();
        rd_expect("R6", 4'd0, 32'h0000_005A);
        pad_in = 16'hA5A5;
        tick(); tick();

        // R8: peripheral functions
        cur_req = "R8";
        fn_dout = {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000};
        fn_den  = {16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF};
        wr(4'd8, 32'h0000_00E4);
        wr(4'd7, 32'h0000_000F);
        check("R8", "pad_out fn", {16'h0, pad_out}, 32'h0000_0FCA);
        check("R8", "pad_oe fn", {16'h0, pad_oe}, 32'h0000_000D);
        wr(4'd8, 32'h0000_001B);
        check("R8", "pad_out fn swap", {16'h0, pad_out}, 32'h0000_0FC5);
        check("R8", "pad_oe fn swap", {16'h0, pad_oe}, 32'h0000_000B);

        // R9: readback of registers and aliases
        cur_req = "R9";
        rd_expect("R9", 4'd8, 32'h0000_001B);
        rd_expect("R9", 4'd7, 32'h0000_000F);
        rd_expect("R9", 4'd1, 32'h0);
        rd_expect("R9", 4'd4, 32'h0);
        rd_expect("R9", 4'd12, 32'h0);

        // R10: unmapped writes ignored
        cur_req = "R10";
        for (int a = 9; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
        bus_addr = 4'd3; tick();
        rd_expect("R10", 4'd3, 32'h0000_0000);
        rd_expect("R10", 4'd6, 32'h0000_00FF);
        rd_expect("R10", 4'd8, 32'h0000_001B);
        check("R10", "pad_out kept", {16'h0, pad_out}, 32'h0000_0FC5);

        // mixed traffic, model-compared every clock
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            bus_wr    = ($urandom % 3) != 0;
            bus_addr  = 4'($urandom % 11);
            bus_wdata = $urandom;
            if (($urandom % 4) == 0) pad_in = 16'($urandom);
            if (($urandom % 16) == 0) begin
                fn_dout = {$urandom, $urandom};
                fn_den  = {$urandom, $urandom};
            end
            tick();
        end
        bus_wr = 1'b0;
        tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule